// File: doc/BRIEF.md
# Delayed Branch Next-PC Unit

This unit resolves conditional branches for a 32-bit classic RISC pipeline that has one architectural branch delay slot. From the fetched branch instruction word, the PC of that word and the two source operand values, it works out four things. It decides whether the word is a conditional branch and whether the branch is taken. It gives the fetch address that follows the delay slot. It also says whether the delay-slot instruction has to be annulled.

There are two kinds of branch. An ordinary branch always executes its delay-slot instruction. A "likely" branch executes it only when the branch is taken. The decode, the condition test and the target arithmetic are all combinational. One registered flag records that the next instruction to be accepted sits in a delay slot. A branch that arrives while this flag is set is reported as illegal.

Top module: `dbr_next_pc_unit`

## Requirements
- R1: `is_branch` is 1 for these primary opcodes (instruction bits 31:26): 0x04, 0x05, 0x06 and 0x07 (ordinary equal, not-equal, less-or-equal-zero, greater-than-zero), and 0x14, 0x15, 0x16 and 0x17 (the likely forms of the same four). It is also 1 for primary opcode 0x01 when bits 20:16 hold a known sub-function. For any other word it is 0.
- R2: The equal branches (0x04, 0x14) are taken when `rs_val == rt_val`. The not-equal branches (0x05, 0x15) are taken when the two values differ.
- R3: Opcodes 0x07 and 0x17 are taken when `rs_val` read as a signed value is greater than zero. Opcodes 0x06 and 0x16 are taken when it is less than or equal to zero.
- R4: Under opcode 0x01, the bits 20:16 select the test: 0x00 is less-than-zero (ordinary), 0x01 is greater-or-equal-zero (ordinary), 0x02 is less-than-zero (likely) and 0x03 is greater-or-equal-zero (likely). All of these read `rs_val` as signed.
- R5: For a taken branch, `next_pc` = `pc` + 4 + (sign-extended bits 15:0 shifted left by 2), with wrap-around modulo 2^32.
- R6: For a branch that is not taken, `next_pc` = `pc` + 8. For a word that is not a branch, `next_pc` = `pc` + 4.
- R7: An ordinary branch never raises `annul_slot`.
- R8: A likely branch raises `annul_slot` exactly when it is not taken.
- R9: `illegal` is 1 for opcode 0x01 with an unknown sub-function (4 to 31), and in that case `is_branch` is 0. `illegal` is also 1 for opcodes 0x06, 0x07, 0x16 and 0x17 when bits 20:16 are nonzero.
- R10: `in_slot` goes to 1 on the clock edge where `issue_valid` is high with a legal branch. It goes to 0 on the next edge where `issue_valid` is high. It holds its value while `issue_valid` is low.
- R11: A branch presented while `in_slot` is 1 is `illegal`. Any illegal word forces `taken` = 0, `annul_slot` = 0 and `next_pc` = `pc` + 8, and does not set `in_slot`.
- R12: After reset, `in_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | The presented instruction is accepted this cycle |
| instr | input | 32 | Fetched instruction word |
| pc | input | 32 | Address of `instr` |
| rs_val | input | 32 | First source operand value |
| rt_val | input | 32 | Second source operand value |
| is_branch | output | 1 | Word is a recognised conditional branch |
| taken | output | 1 | Branch condition holds |
| annul_slot | output | 1 | Delay-slot instruction is to be squashed |
| next_pc | output | 32 | Fetch address after the delay slot |
| illegal | output | 1 | Malformed branch, or branch inside a delay slot |
| in_slot | output | 1 | Next accepted instruction occupies a delay slot |

## Verification
Every one of the twelve branch forms is swept over operand values that sit on the signed boundaries: 0, 1, -1, 0x7fffffff and 0x80000000. These values separate a signed compare from an unsigned one and separate > from >=. For the equality forms, the rs and rt operands are also crossed, which separates == from a sign test. Offsets of 0, 1, -1, 0x7fff and 0x8000 separate correct sign extension and the +4 base from near misses. Comparing ordinary forms with likely forms shows the annul rule. Every sub-function code under the register-immediate opcode, and nonzero rt fields on the zero-compare forms, are used to probe the illegal decode. Short issue sequences then exercise the delay-slot flag: a branch in a slot, and idle cycles between the branch and its slot instruction.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    localparam logic [5:0] OP_REGIMM = 6'h01;
    localparam logic [5:0] OP_EQ     = 6'h04;
    localparam logic [5:0] OP_NE     = 6'h05;
    localparam logic [5:0] OP_LEZ    = 6'h06;
    localparam logic [5:0] OP_GTZ    = 6'h07;
    localparam logic [5:0] OP_EQ_L   = 6'h14;
    localparam logic [5:0] OP_NE_L   = 6'h15;
    localparam logic [5:0] OP_LEZ_L  = 6'h16;
    localparam logic [5:0] OP_GTZ_L  = 6'h17;

    localparam logic [4:0] RI_LTZ    = 5'h00;
    localparam logic [4:0] RI_GEZ    = 5'h01;
    localparam logic [4:0] RI_LTZ_L  = 5'h02;
    localparam logic [4:0] RI_GEZ_L  = 5'h03;

    typedef enum logic [2:0] {
        CND_EQ,
        CND_NE,
        CND_LEZ,
        CND_GTZ,
        CND_LTZ,
        CND_GEZ
    } cond_e;

    typedef struct packed {
        logic  br;       // recognised branch
        logic  likely;   // annuls slot when not taken
        cond_e cond;     // condition to evaluate
        logic  bad_fmt;  // malformed encoding
    } dec_t;

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0] op;
    logic [4:0] sub;

    assign op  = instr[31:26];
    assign sub = instr[20:16];

    always_comb begin
        dec = '{br: 1'b0, likely: 1'b0, cond: CND_EQ, bad_fmt: 1'b0};
        unique case (op)
            OP_EQ, OP_EQ_L: begin
                dec.br     = 1'b1;
                dec.cond   = CND_EQ;
                dec.likely = op[4];
            end
            OP_NE, OP_NE_L: begin
                dec.br     = 1'b1;
                dec.cond   = CND_NE;
                dec.likely = op[4];
            end
            OP_LEZ, OP_LEZ_L: begin
                dec.br      = 1'b1;
                dec.cond    = CND_LEZ;
                dec.likely  = op[4];
                dec.bad_fmt = (sub != 5'd0);
            end
            OP_GTZ, OP_GTZ_L: begin
                dec.br      = 1'b1;
                dec.cond    = CND_GTZ;
                dec.likely  = op[4];
                dec.bad_fmt = (sub != 5'd0);
            end
            OP_REGIMM: begin
                unique case (sub)
                    RI_LTZ:   begin dec.br = 1'b1; dec.cond = CND_LTZ; end
                    RI_GEZ:   begin dec.br = 1'b1; dec.cond = CND_GEZ; end
                    RI_LTZ_L: begin dec.br = 1'b1; dec.cond = CND_LTZ; dec.likely = 1'b1; end
                    RI_GEZ_L: begin dec.br = 1'b1; dec.cond = CND_GEZ; dec.likely = 1'b1; end
                    default:  dec.bad_fmt = 1'b1;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbr_cond.sv
module dbr_cond
    import dbr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  cond_e           cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit
);
    logic sign_a;
    logic zero_a;
    logic same;

    assign sign_a = a[XLEN-1];
    assign zero_a = (a == '0);
    assign same   = (a == b);

    always_comb begin
        unique case (cond)
            CND_EQ:  hit = same;
            CND_NE:  hit = !same;
            CND_LEZ: hit = sign_a || zero_a;
            CND_GTZ: hit = !sign_a && !zero_a;
            CND_LTZ: hit = sign_a;
            CND_GEZ: hit = !sign_a;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbr_target.sv
module dbr_target #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 16,
    parameter int unsigned ISZ   = 4
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic             br,
    input  logic             take,
    output logic [XLEN-1:0]  next_pc
);
    localparam int unsigned SH = $clog2(ISZ);
    localparam int unsigned EXT = XLEN - IMM_W - SH;

    logic [XLEN-1:0] ofs;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] skip_pc;
    logic [XLEN-1:0] tgt_pc;

    assign ofs     = {{EXT{imm[IMM_W-1]}}, imm, {SH{1'b0}}};
    assign seq_pc  = pc + XLEN'(ISZ);
    assign skip_pc = pc + XLEN'(2 * ISZ);
    assign tgt_pc  = seq_pc + ofs;

    always_comb begin
        if (!br)       next_pc = seq_pc;
        else if (take) next_pc = tgt_pc;
        else           next_pc = skip_pc;
    end
endmodule

// File: rtl/dbr_next_pc_unit.sv
module dbr_next_pc_unit
    import dbr_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic            is_branch,
    output logic            taken,
    output logic            annul_slot,
    output logic [XLEN-1:0] next_pc,
    output logic            illegal,
    output logic            in_slot
);
    typedef struct packed {
        logic in_slot;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;
    logic   hit;
    logic   bad;
    logic   go;

    dbr_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    dbr_cond #(.XLEN(XLEN)) u_cond (
        .cond (dec.cond),
        .a    (rs_val),
        .b    (rt_val),
        .hit  (hit)
    );

    assign bad = dec.bad_fmt || (dec.br && st_q.in_slot);
    assign go  = dec.br && !bad && hit;

    dbr_target #(.XLEN(XLEN), .IMM_W(IMM_W), .ISZ(4)) u_tgt (
        .pc      (pc),
        .imm     (instr[IMM_W-1:0]),
        .br      (dec.br || bad),
        .take    (go),
        .next_pc (next_pc)
    );

    always_comb begin
        st_d = st_q;
        if (issue_valid) st_d.in_slot = dec.br && !bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_branch  = dec.br;
    assign taken      = go;
    assign annul_slot = dec.br && !bad && dec.likely && !hit;
    assign illegal    = bad;
    assign in_slot    = st_q.in_slot;
endmodule

// File: rtl/dbr_next_pc_chk.sv
module dbr_next_pc_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic [XLEN-1:0] pc,
    input logic            is_branch,
    input logic            taken,
    input logic            annul_slot,
    input logic [XLEN-1:0] next_pc,
    input logic            illegal,
    input logic            in_slot
);
    assert_taken_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (is_branch && !illegal));

    assert_annul_untaken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        annul_slot |-> (is_branch && !taken && !illegal));

    assert_skip_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_branch && !taken) |-> (next_pc == pc + XLEN'(8)));

    assert_slot_branch_bad_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && is_branch) |-> illegal);

    assert_slot_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && is_branch && !illegal) |=> in_slot);

    assert_slot_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && in_slot) |=> !in_slot);

    assert_slot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(in_slot));
endmodule

bind dbr_next_pc_unit dbr_next_pc_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .pc          (pc),
    .is_branch   (is_branch),
    .taken       (taken),
    .annul_slot  (annul_slot),
    .next_pc     (next_pc),
    .illegal     (illegal),
    .in_slot     (in_slot)
);

// File: tb/tb_dbr_next_pc_unit.sv
module tb_dbr_next_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic        is_branch, taken, annul_slot, illegal, in_slot;
    logic [31:0] next_pc;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dbr_next_pc_unit dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .pc(pc), .rs_val(rs_val), .rt_val(rt_val), .is_branch(is_branch),
        .taken(taken), .annul_slot(annul_slot), .next_pc(next_pc),
        .illegal(illegal), .in_slot(in_slot)
    );

    // expected = {br, tk, an, il, next_pc}
    function automatic logic [35:0] model(input logic [31:0] w, input logic [31:0] p,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic slot);
        logic [5:0] op;
        logic [4:0] f;
        logic br, lk, c, il, tk, an;
        logic [31:0] np;
        op = w[31:26]; f = w[20:16];
        br = 0; lk = 0; c = 0; il = 0;
        case (op)
            6'h04, 6'h14: begin br = 1; c = (a == b); end
            6'h05, 6'h15: begin br = 1; c = (a != b); end
            6'h06, 6'h16: begin br = 1; c = ($signed(a) <= 0); il = (f != 0); end
            6'h07, 6'h17: begin br = 1; c = ($signed(a) > 0); il = (f != 0); end
            6'h01: begin
                if (f <= 5'd3) begin
                    br = 1;
                    c = f[0] ? ($signed(a) >= 0) : ($signed(a) < 0);
                    lk = f[1];
                end else il = 1;
            end
            default: ;
        endcase
        if (op != 6'h01) lk = op[4];
        if (br && slot) il = 1;
        tk = br && !il && c;
        an = br && !il && lk && !c;
        if (!br && !il) np = p + 32'd4;
        else if (tk) np = p + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
        else np = p + 32'd8;
        return {br, tk, an, il, np};
    endfunction

    task automatic check(input string req, input logic slot);
        logic [35:0] e, g;
        e = model(instr, pc, rs_val, rt_val, slot);
        g = {is_branch, taken, annul_slot, illegal, next_pc};
        n_vec++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s instr=%h rs=%h rt=%h got br%b tk%b an%b il%b pc=%h exp br%b tk%b an%b il%b pc=%h",
                     req, instr, rs_val, rt_val, g[35], g[34], g[33], g[32], g[31:0],
                     e[35], e[34], e[33], e[32], e[31:0]);
        end
    endtask

    task automatic check_slot(input string req, input logic exp);
        n_vec++;
        if (in_slot !== exp) begin
            n_bad++;
            $display("FAIL %s in_slot got %b exp %b", req, in_slot, exp);
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] vals [6];
        logic [15:0] offs [5];
        logic [10:0] forms [12];
        vals = '{32'h0, 32'h1, 32'hffffffff, 32'h7fffffff, 32'h80000000, 32'h1234abcd};
        offs = '{16'h0000, 16'h0001, 16'hffff, 16'h7fff, 16'h8000};
        // {opcode, rt field}
        forms = '{{6'h04, 5'd9}, {6'h05, 5'd9}, {6'h06, 5'd0}, {6'h07, 5'd0},
                  {6'h14, 5'd9}, {6'h15, 5'd9}, {6'h16, 5'd0}, {6'h17, 5'd0},
                  {6'h01, 5'd0}, {6'h01, 5'd1}, {6'h01, 5'd2}, {6'h01, 5'd3}};

        // R12: reset state
        #5;
        check_slot("R12 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_slot("R12 after release", 1'b0);

        // R1 R2 R3 R4 R5 R6 R7 R8 sweep with issue_valid low
        pc = 32'h0040_1000;
        for (int fi = 0; fi < 12; fi++)
            for (int ai = 0; ai < 6; ai++)
                for (int bi = 0; bi < 6; bi++)
                    for (int oi = 0; oi < 5; oi++) begin
                        instr = {forms[fi][10:5], 5'd3, forms[fi][4:0], offs[oi]};
                        rs_val = vals[ai];
                        rt_val = vals[bi];
                        #1;
                        check("R1-sweep R2 R3 R4 R5 R6 R7 R8", 1'b0);
                    end

        // R5: target wrap at top and bottom of address space
        instr = {6'h04, 5'd1, 5'd1, 16'h0010}; rs_val = 0; rt_val = 0;
        pc = 32'hffff_fff0; #1; check("R5 wrap up", 1'b0);
        instr = {6'h04, 5'd1, 5'd1, 16'hfff0};
        pc = 32'h0000_0004; #1; check("R5 wrap down", 1'b0);

        // R9: every REGIMM sub-function
        pc = 32'h100;
        for (int f = 0; f < 32; f++) begin
            instr = {6'h01, 5'd2, f[4:0], 16'h0004};
            rs_val = 32'h5; #1;
            check("R9 regimm fn", 1'b0);
        end
        // R9: nonzero rt on zero-compare forms
        for (int k = 0; k < 4; k++) begin
            instr = {(k[1] ? 6'h16 : 6'h06) | {5'b0, k[0]}, 5'd2, 5'd7, 16'h0004};
            rs_val = 32'h0; #1;
            check("R9 rt nonzero", 1'b0);
        end
        // R6: non-branch word
        instr = {6'h08, 5'd1, 5'd2, 16'h0005}; #1;
        check("R6 non-branch", 1'b0);

        // R10 R11: delay-slot sequencing
        @(negedge clk);
        instr = {6'h04, 5'd1, 5'd1, 16'h0020}; rs_val = 1; rt_val = 1; issue_valid = 1;
        #1; check("R10 branch issue", 1'b0);
        @(negedge clk);
        issue_valid = 0;
        check_slot("R10 set", 1'b1);
        @(negedge clk);
        check_slot("R10 hold idle", 1'b1);
        #1; check("R11 branch in slot", 1'b1);
        issue_valid = 1;
        @(negedge clk);
        issue_valid = 0;
        check_slot("R11 no re-arm", 1'b0);
        // branch then plain slot instruction clears
        issue_valid = 1; instr = {6'h15, 5'd1, 5'd2, 16'h0003};
        @(negedge clk);
        check_slot("R10 set likely", 1'b1);
        instr = {6'h08, 5'd1, 5'd2, 16'h0001};
        @(negedge clk);
        issue_valid = 0;
        check_slot("R10 clear", 1'b0);
        // illegal format branch does not arm
        instr = {6'h07, 5'd1, 5'd4, 16'h0003}; issue_valid = 1;
        @(negedge clk);
        issue_valid = 0;
        check_slot("R11 malformed no arm", 1'b0);
        // unknown regimm does not arm
        instr = {6'h01, 5'd1, 5'd17, 16'h0003}; issue_valid = 1;
        @(negedge clk);
        issue_valid = 0;
        check_slot("R9 unknown fn no arm", 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule